// File: doc/BRIEF.md
# Deferred Serial Configuration Shadow Registers

This block sits between a host register port and the live configuration of a serial channel. Host writes to the channel's operating mode, port value, data format and baud divisor never land in the live registers straight away. They are held in shadow copies and a single pending flag is raised. The whole set is copied to the live registers at once, as one group, on a cycle when the transmitter reports that it is idle. This keeps a character that is being shifted out from being corrupted by a change of format, rate or line control in the middle of it.

The host drives one write strobe with a 3-bit command select and a data word. Besides plain shadow writes, there are commands that assert or release RTS, assert or release DTR, and set or clear the transmit break bit. Each of these edits only the bits it owns in the matching shadow. The 10-bit baud divisor is split when it is committed. Its low byte goes to a baud-low register. Its top two bits go into the top of a second control register, and the lower bits of that register are kept. Those lower bits are written directly by their own command.

Top module: `serial_cfg_defer`

## Requirements
- R1: After reset, cfg_pending is 0, live_mode = 8'h44, live_port = 8'h02, live_fmt = 8'h00, live_baud_lo = 8'h00 and live_ctl2 = 8'h00. The shadows hold the same values, with a baud shadow of 0.
- R2: A shadow command (wr_sel 0 mode, 1 port, 2 format, 3 baud, 4 RTS, 5 DTR, 6 break) strobed while tx_idle is 0 sets cfg_pending at the next edge and leaves live_mode, live_port, live_fmt and live_baud_lo unchanged.
- R3: A shadow command strobed while tx_idle is 1 is committed at the same edge, including the new value, and cfg_pending stays 0.
- R4: On any edge where cfg_pending is 1 and tx_idle is 1, all four shadows are copied to the live registers together and cfg_pending clears.
- R5: On commit, live_baud_lo takes baud bits 7:0 and live_ctl2 bits 7:6 take baud bits 9:8.
- R6: live_ctl2 bits 5:0 change only through wr_sel 7, which writes wr_data[5:0] at the next edge whatever tx_idle is, does not set cfg_pending, and is kept unchanged by every commit.
- R7: wr_sel 4 with wr_data[0]=1 (request RTS) clears mode bit 6 (forced RTS) and sets mode bit 2 (RTS). With wr_data[0]=0 it sets both bits. Other mode bits are kept. The effect reaches live_mode only through a commit.
- R8: wr_sel 5 with wr_data[0]=1 (assert DTR) clears port bit 1, which is active low. With wr_data[0]=0 it sets that bit. Other port bits are kept. The change is deferred like any other.
- R9: wr_sel 6 with wr_data[0]=1 sets format bit 6 (transmit break) and with wr_data[0]=0 clears it, keeping the other format bits. The change is deferred to a commit.
- R10: With no strobe and tx_idle at 0, every live output and cfg_pending hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one cycle per command |
| wr_sel | input | 3 | Command select |
| wr_data | input | 10 | Command data; baud uses all bits, byte writes use 7:0 |
| tx_idle | input | 1 | Transmitter idle, level sensitive |
| cfg_pending | output | 1 | Shadows hold changes not yet committed |
| live_mode | output | 8 | Live operating mode with RTS controls |
| live_port | output | 8 | Live port value with DTR line |
| live_fmt | output | 8 | Live data format with break bit |
| live_baud_lo | output | 8 | Live baud divisor bits 7:0 |
| live_ctl2 | output | 8 | Live control register 2: baud bits 9:8 on top, host bits below |

## Verification
The assertions assume that tx_idle and the write strobe are clean levels sampled at the clock edge, and that the only path into the low bits of the second control register is command 7. The bench drives every input after the falling edge, so each value is stable across the rising edge that samples it. Its random phase picks command, data and idle level freely within the 3-bit select, because the block accepts every encoding. This puts writes that land on idle cycles, on busy cycles and on commit cycles into the same run.

// File: rtl/cfg_defer_pkg.sv
// Shared command encoding for the deferred serial configuration block.
// Assumes a 3-bit command select on the host write port.
package cfg_defer_pkg;

    typedef enum logic [2:0] {
        CMD_MODE     = 3'd0,
        CMD_PORT     = 3'd1,
        CMD_FMT      = 3'd2,
        CMD_BAUD     = 3'd3,
        CMD_RTS      = 3'd4,
        CMD_DTR      = 3'd5,
        CMD_BRK      = 3'd6,
        CMD_CTL2_LOW = 3'd7
    } cfg_cmd_e;

    // True for commands that touch a deferred shadow
    function automatic logic is_shadow_cmd(cfg_cmd_e c);
        return c != CMD_CTL2_LOW;
    endfunction

endpackage

// File: rtl/cfg_shadow_bank.sv
// Shadow copies of mode, port value, data format and baud divisor.
// Applies host commands and presents the post-write ("next") shadow values,
// so that a commit on the same edge as a write takes the new value.
// Assumes BAUD_W >= REG_W and bit positions inside REG_W.
module cfg_shadow_bank
    import cfg_defer_pkg::*;
#(
    parameter int              REG_W     = 8,
    parameter int              BAUD_W    = 10,
    parameter int              RTS_BIT   = 2,
    parameter int              FRTS_BIT  = 6,
    parameter int              DTR_BIT   = 1,
    parameter int              BRK_BIT   = 6,
    parameter logic [REG_W-1:0]  MODE_RST = 8'h44,
    parameter logic [REG_W-1:0]  PORT_RST = 8'h02,
    parameter logic [REG_W-1:0]  FMT_RST  = 8'h00,
    parameter logic [BAUD_W-1:0] BAUD_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  cfg_cmd_e          cmd,
    input  logic [BAUD_W-1:0] wr_data,
    output logic              shadow_wr,
    output logic [REG_W-1:0]  mode_nxt,
    output logic [REG_W-1:0]  port_nxt,
    output logic [REG_W-1:0]  fmt_nxt,
    output logic [BAUD_W-1:0] baud_nxt
);

    logic [REG_W-1:0]  mode_q, port_q, fmt_q;
    logic [BAUD_W-1:0] baud_q;
    logic              flag;

    assign flag      = wr_data[0];
    assign shadow_wr = wr_en && is_shadow_cmd(cmd);

    // Compute shadow values after this cycle's command
    always_comb begin
        mode_nxt = mode_q;
        port_nxt = port_q;
        fmt_nxt  = fmt_q;
        baud_nxt = baud_q;
        if (wr_en) begin
            unique case (cmd)
                CMD_MODE: mode_nxt = wr_data[REG_W-1:0];
                CMD_PORT: port_nxt = wr_data[REG_W-1:0];
                CMD_FMT:  fmt_nxt  = wr_data[REG_W-1:0];
                CMD_BAUD: baud_nxt = wr_data;
                CMD_RTS: begin
                    mode_nxt[RTS_BIT]  = 1'b1;
                    mode_nxt[FRTS_BIT] = !flag;
                end
                CMD_DTR:  port_nxt[DTR_BIT] = !flag;
                CMD_BRK:  fmt_nxt[BRK_BIT]  = flag;
                default: ;
            endcase
        end
    end

    // Hold the shadow registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
            port_q <= PORT_RST;
            fmt_q  <= FMT_RST;
            baud_q <= BAUD_RST;
        end else begin
            mode_q <= mode_nxt;
            port_q <= port_nxt;
            fmt_q  <= fmt_nxt;
            baud_q <= baud_nxt;
        end
    end

endmodule

// File: rtl/cfg_commit_ctl.sv
// Pending flag and commit decision. A commit fires on any cycle where the
// transmitter is idle and there is something to apply: either an older
// pending change or a shadow write in this very cycle.
// Assumes tx_idle is a synchronous level.
module cfg_commit_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic shadow_wr,
    input  logic tx_idle,
    output logic commit,
    output logic pending
);

    // Decide whether this edge commits
    always_comb commit = tx_idle && (pending || shadow_wr);

    // Track changes not yet copied to the live registers
    always_ff @(posedge clk) begin
        if (!rst_n)      pending <= 1'b0;
        else if (commit) pending <= 1'b0;
        else if (shadow_wr) pending <= 1'b1;
    end

endmodule

// File: rtl/cfg_live_bank.sv
// Live configuration registers. On commit all shadows are loaded together;
// the baud divisor is split into a low byte and a high field packed into the
// top of control register 2 whose remaining bits are preserved.
// Assumes REG_W <= BAUD_W <= 2*REG_W.
module cfg_live_bank #(
    parameter int                REG_W    = 8,
    parameter int                BAUD_W   = 10,
    parameter logic [REG_W-1:0]  MODE_RST = 8'h44,
    parameter logic [REG_W-1:0]  PORT_RST = 8'h02,
    parameter logic [REG_W-1:0]  FMT_RST  = 8'h00,
    parameter logic [BAUD_W-1:0] BAUD_RST = '0,
    parameter logic [REG_W-1:0]  CTL2_RST = 8'h00,
    localparam int BAUD_HI_W  = BAUD_W - REG_W,
    localparam int CTL2_LO_W  = REG_W - BAUD_HI_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [REG_W-1:0]     mode_nxt,
    input  logic [REG_W-1:0]     port_nxt,
    input  logic [REG_W-1:0]     fmt_nxt,
    input  logic [BAUD_W-1:0]    baud_nxt,
    input  logic                 ctl2_wr,
    input  logic [CTL2_LO_W-1:0] ctl2_data,
    output logic [REG_W-1:0]     live_mode,
    output logic [REG_W-1:0]     live_port,
    output logic [REG_W-1:0]     live_fmt,
    output logic [REG_W-1:0]     live_baud_lo,
    output logic [REG_W-1:0]     live_ctl2
);

    // Load the directly mapped registers as one group on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_mode    <= MODE_RST;
            live_port    <= PORT_RST;
            live_fmt     <= FMT_RST;
            live_baud_lo <= BAUD_RST[REG_W-1:0];
        end else if (commit) begin
            live_mode    <= mode_nxt;
            live_port    <= port_nxt;
            live_fmt     <= fmt_nxt;
            live_baud_lo <= baud_nxt[REG_W-1:0];
        end
    end

    // Host-owned low bits of control register 2: written directly
    always_ff @(posedge clk) begin
        if (!rst_n)       live_ctl2[CTL2_LO_W-1:0] <= CTL2_RST[CTL2_LO_W-1:0];
        else if (ctl2_wr) live_ctl2[CTL2_LO_W-1:0] <= ctl2_data;
    end

    generate
        if (BAUD_HI_W > 0) begin : g_baud_hi
            // Read-modify-write of the baud high field on commit
            always_ff @(posedge clk) begin
                if (!rst_n)
                    live_ctl2[REG_W-1 -: BAUD_HI_W] <= BAUD_RST[BAUD_W-1 -: BAUD_HI_W];
                else if (commit)
                    live_ctl2[REG_W-1 -: BAUD_HI_W] <= baud_nxt[BAUD_W-1 -: BAUD_HI_W];
            end
        end
    endgenerate

endmodule

// File: rtl/serial_cfg_defer.sv
// Top of the deferred serial configuration block. Host commands edit shadow
// copies; a pending flag tracks unapplied changes; the whole set is copied to
// the live outputs on a transmitter-idle cycle. Control register 2 low bits
// are host-written directly and never deferred.
// Assumes one command per strobe and a synchronous tx_idle level.
module serial_cfg_defer
    import cfg_defer_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int BAUD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [BAUD_W-1:0] wr_data,
    input  logic              tx_idle,
    output logic              cfg_pending,
    output logic [REG_W-1:0]  live_mode,
    output logic [REG_W-1:0]  live_port,
    output logic [REG_W-1:0]  live_fmt,
    output logic [REG_W-1:0]  live_baud_lo,
    output logic [REG_W-1:0]  live_ctl2
);

    localparam int CTL2_LO_W = REG_W - (BAUD_W - REG_W);

    cfg_cmd_e          cmd;
    logic              shadow_wr, commit, ctl2_wr;
    logic [REG_W-1:0]  mode_nxt, port_nxt, fmt_nxt;
    logic [BAUD_W-1:0] baud_nxt;

    assign cmd     = cfg_cmd_e'(wr_sel);
    assign ctl2_wr = wr_en && (cmd == CMD_CTL2_LOW);

    cfg_shadow_bank #(.REG_W(REG_W), .BAUD_W(BAUD_W)) i_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd(cmd), .wr_data(wr_data),
        .shadow_wr(shadow_wr), .mode_nxt(mode_nxt), .port_nxt(port_nxt),
        .fmt_nxt(fmt_nxt), .baud_nxt(baud_nxt)
    );

    cfg_commit_ctl i_commit (
        .clk(clk), .rst_n(rst_n), .shadow_wr(shadow_wr), .tx_idle(tx_idle),
        .commit(commit), .pending(cfg_pending)
    );

    cfg_live_bank #(.REG_W(REG_W), .BAUD_W(BAUD_W)) i_live (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .mode_nxt(mode_nxt), .port_nxt(port_nxt), .fmt_nxt(fmt_nxt),
        .baud_nxt(baud_nxt), .ctl2_wr(ctl2_wr),
        .ctl2_data(wr_data[CTL2_LO_W-1:0]),
        .live_mode(live_mode), .live_port(live_port), .live_fmt(live_fmt),
        .live_baud_lo(live_baud_lo), .live_ctl2(live_ctl2)
    );

endmodule

// File: rtl/cfg_defer_checker.sv
// Timing properties of the deferred configuration block, observed at ports.
module cfg_defer_checker #(
    parameter int REG_W  = 8,
    parameter int BAUD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [BAUD_W-1:0] wr_data,
    input logic              tx_idle,
    input logic              cfg_pending,
    input logic [REG_W-1:0]  live_mode,
    input logic [REG_W-1:0]  live_port,
    input logic [REG_W-1:0]  live_fmt,
    input logic [REG_W-1:0]  live_baud_lo,
    input logic [REG_W-1:0]  live_ctl2
);

    localparam int CL = REG_W - (BAUD_W - REG_W);

    logic sh_cmd;
    assign sh_cmd = wr_en && (wr_sel != 3'd7);

    // R2: busy transmitter freezes the deferred live registers
    a_r2_live_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle |=> $stable({live_mode, live_port, live_fmt, live_baud_lo,
                              live_ctl2[REG_W-1:CL]}));

    // R2: a shadow write on a busy cycle leaves a change pending
    a_r2_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_cmd && !tx_idle) |=> cfg_pending);

    // R3: a shadow write on an idle cycle is committed at once
    a_r3_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_cmd && tx_idle) |=> !cfg_pending);

    // R4: pending and idle together always commit and clear pending
    a_r4_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pending && tx_idle) |=> !cfg_pending);

    // R6: host bits of control register 2 only move on command 7
    a_r6_ctl2_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 3'd7) |=> $stable(live_ctl2[CL-1:0]));

    // R10: nothing moves without a strobe while busy
    a_r10_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tx_idle) |=> $stable(cfg_pending));

endmodule

bind serial_cfg_defer cfg_defer_checker #(.REG_W(REG_W), .BAUD_W(BAUD_W)) i_chk (.*);

// File: tb/test_serial_cfg_defer.sv
`timescale 1ns/1ps
module test_serial_cfg_defer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [9:0] wr_data = '0;
    logic       tx_idle = 1'b0;
    logic       cfg_pending;
    logic [7:0] live_mode, live_port, live_fmt, live_baud_lo, live_ctl2;

    int checks = 0;
    int failures = 0;

    // Bench model of shadows, live registers and pending flag
    logic [7:0] m_mode, m_port, m_fmt, e_mode, e_port, e_fmt, e_blo, e_ctl2;
    logic [9:0] m_baud;
    logic       e_pend;

    always #5 clk = ~clk;

    serial_cfg_defer i_serial_cfg_defer (.*);

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "pending",  16'(cfg_pending),  16'(e_pend));
        check(req, "mode",     16'(live_mode),    16'(e_mode));
        check(req, "port",     16'(live_port),    16'(e_port));
        check(req, "fmt",      16'(live_fmt),     16'(e_fmt));
        check(req, "baud_lo",  16'(live_baud_lo), 16'(e_blo));
        check(req, "ctl2",     16'(live_ctl2),    16'(e_ctl2));
    endtask

    task automatic model_reset();
        m_mode = 8'h44; m_port = 8'h02; m_fmt = 8'h00; m_baud = '0;
        e_mode = 8'h44; e_port = 8'h02; e_fmt = 8'h00; e_blo = 8'h00;
        e_ctl2 = 8'h00; e_pend = 1'b0;
    endtask

    // Model one clock edge from the requirements R2..R9
    task automatic model_edge(input logic we, input logic [2:0] sel, input logic [9:0] d, input logic idle);
        logic sw;
        sw = we && (sel != 3'd7);
        if (we) begin
            case (sel)
                3'd0: m_mode = d[7:0];
                3'd1: m_port = d[7:0];
                3'd2: m_fmt  = d[7:0];
                3'd3: m_baud = d;
                3'd4: begin m_mode[2] = 1'b1; m_mode[6] = !d[0]; end
                3'd5: m_port[1] = !d[0];
                3'd6: m_fmt[6]  = d[0];
                default: e_ctl2[5:0] = d[5:0];
            endcase
        end
        if (idle && (e_pend || sw)) begin
            e_mode = m_mode; e_port = m_port; e_fmt = m_fmt;
            e_blo = m_baud[7:0]; e_ctl2[7:6] = m_baud[9:8];
            e_pend = 1'b0;
        end else if (sw) begin
            e_pend = 1'b1;
        end
    endtask

    task automatic step(input string req, input logic we, input logic [2:0] sel, input logic [9:0] d, input logic idle);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; tx_idle = idle;
        @(posedge clk);
        model_edge(we, sel, d, idle);
        #1;
        check_all(req);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check_all("R1 reset");

        // R2: busy writes stay in the shadows
        step("R2 busy baud write", 1'b1, 3'd3, 10'h2A5, 1'b0);
        check("R2", "pending raised", 16'(cfg_pending), 16'h1);
        step("R2 busy rts request", 1'b1, 3'd4, 10'h001, 1'b0);
        check("R2", "mode unchanged", 16'(live_mode), 16'h44);
        // R10: quiet busy cycles
        step("R10 hold", 1'b0, 3'd0, 10'h3FF, 1'b0);
        step("R10 hold", 1'b0, 3'd3, 10'h000, 1'b0);
        // R4/R5/R7: commit on idle
        step("R4 idle commit", 1'b0, 3'd0, 10'h000, 1'b1);
        check("R5", "baud low", 16'(live_baud_lo), 16'h00A5);
        check("R5", "ctl2 hi", 16'(live_ctl2[7:6]), 16'h2);
        check("R7", "rts request bits", 16'({live_mode[6], live_mode[2]}), 16'h1);
        // R6: direct write of ctl2 low bits, busy
        step("R6 ctl2 low write", 1'b1, 3'd7, 10'h02D, 1'b0);
        check("R6", "ctl2 direct", 16'(live_ctl2), 16'h00AD);
        check("R6", "no pending", 16'(cfg_pending), 16'h0);
        step("R6 baud busy", 1'b1, 3'd3, 10'h1FF, 1'b0);
        step("R6 commit keeps low", 1'b0, 3'd0, 10'h000, 1'b1);
        check("R6", "ctl2 rmw", 16'(live_ctl2), 16'h006D);
        // R3/R8: idle write commits at once
        step("R3 R8 dtr assert idle", 1'b1, 3'd5, 10'h001, 1'b1);
        check("R8", "dtr low", 16'(live_port[1]), 16'h0);
        check("R3", "no pending", 16'(cfg_pending), 16'h0);
        // R9: break deferred then committed
        step("R9 break busy", 1'b1, 3'd6, 10'h001, 1'b0);
        check("R9", "break deferred", 16'(live_fmt[6]), 16'h0);
        step("R9 break commit", 1'b0, 3'd0, 10'h000, 1'b1);
        check("R9", "break set", 16'(live_fmt[6]), 16'h1);
        // R7/R8 release
        step("R7 rts release", 1'b1, 3'd4, 10'h000, 1'b1);
        check("R7", "rts release bits", 16'({live_mode[6], live_mode[2]}), 16'h3);
        step("R8 dtr release", 1'b1, 3'd5, 10'h000, 1'b1);
        check("R8", "dtr high", 16'(live_port[1]), 16'h1);
        // R4: pending commit collides with a new write on the same edge
        step("R4 busy fmt", 1'b1, 3'd2, 10'h055, 1'b0);
        step("R4 write on commit edge", 1'b1, 3'd1, 10'h0F0, 1'b1);

        // Random mix, all requirements R2..R10 via the model
        for (int i = 0; i < 3000; i++) begin
            logic r_we, r_idle;
            r_we   = ($urandom % 3) != 0;
            r_idle = ($urandom % 4) == 0;
            step("R4 R10 random", r_we, 3'($urandom), 10'($urandom), r_idle);
        end

        // R1: reset in the middle returns the defaults
        step("R2 pre-reset", 1'b1, 3'd0, 10'h0AA, 1'b0);
        @(negedge clk) rst_n = 1'b0; wr_en = 1'b0;
        @(posedge clk); #1;
        model_reset();
        @(negedge clk) rst_n = 1'b1;
        #1;
        check_all("R1 mid reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule